// File: doc/BRIEF.md
# Transmitter Power-Up Sequencer

This block steps a high-power transmitter from cold power-on to full modulation and back down. Once the asynchronous reset is released, an internal settling interval runs first. It holds every flip-flop and counter in a synchronous clear. A preheat delay follows. Only after both have run out does the machine accept a high-voltage on command. Trigger and excitation then follow high voltage, each after a programmable gap. All delays are counted in cycles of the reference clock.

A modulation-on command is acted on only once high voltage is up and its ramp gap has elapsed. A modulation-on command raises trigger and then excitation. A modulation-off command lowers them in the reverse order. A high-voltage off command runs the full reverse order. A fault also runs the full reverse order, and the machine then parks in a locked fault state. Two modulator pulses mark the switch-on and switch-off of excitation, and an interlock guarantees they are never high together.

Top module: `tx_powerup_seq`

## Requirements
- R1: While `rst_ni` is low, and through the settling interval after its release, all six outputs are low. A reset asserted at any time clears all outputs at once.
- R2: With `hv_on_req_i` held high from reset release, `hv_en_o` first reads high after clock edge SETTLE_CYC+PREHEAT_CYC+2 counted from the release, and never before.
- R3: `trig_en_o` is high only while `hv_en_o` is high, and `exc_en_o` only while `trig_en_o` is high. With both on commands held, trigger rises GAP_CYC+1 edges after high voltage, and excitation rises GAP_CYC edges after trigger.
- R4: `mod_on_pulse_o` rises at the same edge as `exc_en_o` and stays high PULSE_CYC cycles. `mod_off_pulse_o` rises at the edge where `exc_en_o` falls and stays high PULSE_CYC cycles.
- R5: The two modulator pulses are never high in the same cycle. A switch-off cuts a running switch-on pulse at that edge.
- R6: A modulation-on request is ignored while high voltage is off, and while high voltage is still inside its ramp gap.
- R7: A modulation-off request while running drops excitation at the next edge and trigger one edge later, and keeps high voltage up. A later modulation-on request raises trigger again at the next edge.
- R8: A high-voltage off request while running drops excitation, trigger and high voltage on three consecutive edges. A later on request raises high voltage at the next edge without a new preheat.
- R9: A high `fault_i` while running drops excitation at the next edge, ends any switch-on pulse, and completes the same ordered shutdown. `fault_lock_o` rises at the edge where high voltage falls.
- R10: While `fault_lock_o` is high, high voltage stays off. The lock clears only after `fault_i` is low, `hv_on_req_i` has been seen low, and `hv_on_req_i` is then seen high. High voltage rises at that same edge.
- R11: An off request seen together with its matching on request wins, for both the high-voltage pair and the modulation pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hv_on_req_i | input | 1 | High-voltage on request |
| hv_off_req_i | input | 1 | High-voltage off request |
| mod_on_req_i | input | 1 | Modulation on request |
| mod_off_req_i | input | 1 | Modulation off request |
| fault_i | input | 1 | Qualified fault summary |
| hv_en_o | output | 1 | High-voltage enable |
| trig_en_o | output | 1 | Trigger enable |
| exc_en_o | output | 1 | Excitation enable |
| mod_on_pulse_o | output | 1 | Modulator switch-on pulse |
| mod_off_pulse_o | output | 1 | Modulator switch-off pulse |
| fault_lock_o | output | 1 | Machine parked after a fault shutdown |

## Verification
The state register drives every enable directly, so a wrong state shows at the ports in the same cycle it is entered. Examples are an enable out of order, excitation without trigger, or a lock with high voltage up. A timer or settling counter that is off by one moves a rise edge by exactly one cycle, and exact edge counts expose that. A wrong shutdown target appears within three edges of the stop request, as a missing lock or as high voltage left up or taken down.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_PREHEAT,
    ST_READY,
    ST_HV_RAMP,
    ST_HV_ON,
    ST_TRIG_RAMP,
    ST_RUN,
    ST_DN_EXC,
    ST_DN_TRIG,
    ST_FAULT
  } seq_state_e;

  // numeric order is shutdown priority: larger wins
  typedef enum logic [1:0] {
    TGT_HV_ON = 2'd0,
    TGT_READY = 2'd1,
    TGT_FAULT = 2'd2
  } dn_tgt_e;

  typedef struct packed {
    logic hv_on;
    logic hv_off;
    logic mod_on;
    logic mod_off;
    logic fault;
  } seq_cmd_t;

endpackage

// File: rtl/tx_seq_settle.sv
module tx_seq_settle #(
  parameter int unsigned SETTLE_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (cnt_q != CW'(SETTLE_CYC))  cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == CW'(SETTLE_CYC));
endmodule

// File: rtl/tx_seq_timer.sv
module tx_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tx_seq_mod_pulse.sv
module tx_seq_mod_pulse #(
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_on_i,
  input  logic start_off_i,
  output logic on_o,
  output logic off_o
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] on_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= '0;
      off_q <= '0;
    end else if (clr_i) begin
      on_q  <= '0;
      off_q <= '0;
    end else if (start_off_i) begin
      // switch-off wins and truncates any switch-on in flight
      off_q <= PW'(PULSE_CYC);
      on_q  <= '0;
    end else begin
      if (off_q != '0) off_q <= off_q - PW'(1);
      if (start_on_i && off_q == '0) on_q <= PW'(PULSE_CYC);
      else if (on_q != '0)           on_q <= on_q - PW'(1);
    end
  end

  assign on_o  = (on_q != '0);
  assign off_o = (off_q != '0);
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_seq_pkg::*;
#(
  parameter int unsigned PREHEAT_CYC = 40000,
  parameter int unsigned GAP_CYC     = 40,
  parameter int unsigned TW          = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          init_done_i,
  input  logic          tmr_zero_i,
  input  seq_cmd_t      cmd_i,
  output seq_state_e    state_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          start_on_o,
  output logic          start_off_o
);
  localparam logic [TW-1:0] PREHEAT_LD = TW'(PREHEAT_CYC - 1);
  localparam logic [TW-1:0] GAP_LD     = TW'(GAP_CYC - 1);

  seq_state_e state_q, state_d;
  dn_tgt_e    tgt_q, tgt_d, req_tgt, up_tgt;
  logic       arm_q, arm_d;
  logic       stop_req;

  // shutdown request and its target, highest priority first
  always_comb begin
    stop_req = cmd_i.fault | cmd_i.hv_off | cmd_i.mod_off;
    if (cmd_i.fault)       req_tgt = TGT_FAULT;
    else if (cmd_i.hv_off) req_tgt = TGT_READY;
    else                   req_tgt = TGT_HV_ON;
    up_tgt = tgt_q;
    if (stop_req && (req_tgt > tgt_q)) up_tgt = req_tgt;
  end

  always_comb begin
    state_d     = state_q;
    tgt_d       = tgt_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = GAP_LD;
    start_on_o  = 1'b0;
    start_off_o = 1'b0;
    arm_d       = 1'b0;

    unique case (state_q)
      ST_SETTLE: begin
        if (init_done_i) begin
          state_d    = ST_PREHEAT;
          tmr_load_o = 1'b1;
          tmr_val_o  = PREHEAT_LD;
        end
      end
      ST_PREHEAT: begin
        if (tmr_zero_i) state_d = ST_READY;
      end
      ST_READY: begin
        if (cmd_i.fault) begin
          state_d = ST_FAULT;
        end else if (cmd_i.hv_on && !cmd_i.hv_off) begin
          state_d    = ST_HV_RAMP;
          tmr_load_o = 1'b1;
        end
      end
      ST_HV_RAMP: begin
        if (cmd_i.fault)       state_d = ST_FAULT;
        else if (cmd_i.hv_off) state_d = ST_READY;
        else if (tmr_zero_i)   state_d = ST_HV_ON;
      end
      ST_HV_ON: begin
        if (cmd_i.fault) begin
          state_d = ST_FAULT;
        end else if (cmd_i.hv_off) begin
          state_d = ST_READY;
        end else if (cmd_i.mod_on && !cmd_i.mod_off) begin
          state_d    = ST_TRIG_RAMP;
          tmr_load_o = 1'b1;
        end
      end
      ST_TRIG_RAMP: begin
        if (stop_req) begin
          state_d = ST_DN_TRIG;
          tgt_d   = req_tgt;
        end else if (tmr_zero_i) begin
          state_d    = ST_RUN;
          start_on_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (stop_req) begin
          state_d     = ST_DN_EXC;
          tgt_d       = req_tgt;
          start_off_o = 1'b1;
        end
      end
      ST_DN_EXC: begin
        state_d = ST_DN_TRIG;
        tgt_d   = up_tgt;
      end
      ST_DN_TRIG: begin
        unique case (up_tgt)
          TGT_FAULT: state_d = ST_FAULT;
          TGT_READY: state_d = ST_READY;
          default:   state_d = ST_HV_ON;
        endcase
        tgt_d = TGT_HV_ON;
      end
      ST_FAULT: begin
        // fresh on command: request must be seen low after the fault clears
        arm_d = arm_q | (!cmd_i.fault && !cmd_i.hv_on);
        if (arm_q && cmd_i.hv_on && !cmd_i.hv_off && !cmd_i.fault) begin
          state_d    = ST_HV_RAMP;
          tmr_load_o = 1'b1;
          arm_d      = 1'b0;
        end
      end
      default: state_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETTLE;
      tgt_q   <= TGT_HV_ON;
      arm_q   <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_SETTLE;
      tgt_q   <= TGT_HV_ON;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      arm_q   <= arm_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/tx_powerup_seq.sv
module tx_powerup_seq
  import tx_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 4000,
  parameter int unsigned PREHEAT_CYC = 40000,
  parameter int unsigned GAP_CYC     = 40,
  parameter int unsigned PULSE_CYC   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hv_on_req_i,
  input  logic hv_off_req_i,
  input  logic mod_on_req_i,
  input  logic mod_off_req_i,
  input  logic fault_i,
  output logic hv_en_o,
  output logic trig_en_o,
  output logic exc_en_o,
  output logic mod_on_pulse_o,
  output logic mod_off_pulse_o,
  output logic fault_lock_o
);
  localparam int unsigned TMR_MAX = (PREHEAT_CYC > GAP_CYC) ? PREHEAT_CYC : GAP_CYC;
  localparam int unsigned TW      = $clog2(TMR_MAX + 1);

  logic          init_done, soft_clr;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          start_on, start_off;
  seq_cmd_t      cmd;
  seq_state_e    state;

  assign cmd = '{hv_on:   hv_on_req_i,
                 hv_off:  hv_off_req_i,
                 mod_on:  mod_on_req_i,
                 mod_off: mod_off_req_i,
                 fault:   fault_i};

  tx_seq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (init_done)
  );

  // internal reset: synchronous clear of all state until settled
  assign soft_clr = !init_done;

  tx_seq_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_clr),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  tx_seq_fsm #(
    .PREHEAT_CYC (PREHEAT_CYC),
    .GAP_CYC     (GAP_CYC),
    .TW          (TW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_clr),
    .init_done_i (init_done),
    .tmr_zero_i  (tmr_zero),
    .cmd_i       (cmd),
    .state_o     (state),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .start_on_o  (start_on),
    .start_off_o (start_off)
  );

  tx_seq_mod_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_clr),
    .start_on_i  (start_on),
    .start_off_i (start_off),
    .on_o        (mod_on_pulse_o),
    .off_o       (mod_off_pulse_o)
  );

  always_comb begin
    hv_en_o      = 1'b0;
    trig_en_o    = 1'b0;
    exc_en_o     = 1'b0;
    fault_lock_o = 1'b0;
    unique case (state)
      ST_HV_RAMP, ST_HV_ON, ST_DN_TRIG: hv_en_o = 1'b1;
      ST_TRIG_RAMP, ST_DN_EXC: begin
        hv_en_o   = 1'b1;
        trig_en_o = 1'b1;
      end
      ST_RUN: begin
        hv_en_o   = 1'b1;
        trig_en_o = 1'b1;
        exc_en_o  = 1'b1;
      end
      ST_FAULT: fault_lock_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tx_powerup_seq_chk.sv
module tx_powerup_seq_chk #(
  parameter int unsigned SETTLE_CYC  = 4000,
  parameter int unsigned PREHEAT_CYC = 40000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fault_i,
  input logic hv_en_o,
  input logic trig_en_o,
  input logic exc_en_o,
  input logic mod_on_pulse_o,
  input logic mod_off_pulse_o,
  input logic fault_lock_o
);
  localparam logic [31:0] WARM_LIM = 32'(SETTLE_CYC + PREHEAT_CYC + 2);

  logic [31:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_q <= '0;
    else if (since_q != WARM_LIM) since_q <= since_q + 32'd1;
  end

  AST_HV_AFTER_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> (since_q >= WARM_LIM)); // R2

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mod_on_pulse_o && mod_off_pulse_o)); // R5

  AST_TRIG_NEEDS_HV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_en_o |-> hv_en_o); // R3

  AST_EXC_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_en_o |-> trig_en_o); // R3

  AST_EXC_FALLS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_en_o) |-> !$past(exc_en_o)); // R8

  AST_TRIG_BEFORE_HV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hv_en_o) |-> !$past(trig_en_o)); // R8

  AST_FAULT_CUTS_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !exc_en_o); // R9

  AST_LOCK_NO_HV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_lock_o |-> !hv_en_o); // R10
endmodule

bind tx_powerup_seq tx_powerup_seq_chk #(
  .SETTLE_CYC  (SETTLE_CYC),
  .PREHEAT_CYC (PREHEAT_CYC)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fault_i         (fault_i),
  .hv_en_o         (hv_en_o),
  .trig_en_o       (trig_en_o),
  .exc_en_o        (exc_en_o),
  .mod_on_pulse_o  (mod_on_pulse_o),
  .mod_off_pulse_o (mod_off_pulse_o),
  .fault_lock_o    (fault_lock_o)
);

// File: tb/tb_tx_powerup_seq.sv
module tb_tx_powerup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;
  localparam int P = 20;
  localparam int G = 3;
  localparam int W = 2;

  logic clk, rst_n;
  logic hv_on, hv_off, mod_on, mod_off, fault;
  logic hv, trig, exc, pon, poff, lock;

  int n_chk  = 0;
  int n_fail = 0;

  tx_powerup_seq #(
    .SETTLE_CYC(S), .PREHEAT_CYC(P), .GAP_CYC(G), .PULSE_CYC(W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hv_on_req_i(hv_on), .hv_off_req_i(hv_off),
    .mod_on_req_i(mod_on), .mod_off_req_i(mod_off), .fault_i(fault),
    .hv_en_o(hv), .trig_en_o(trig), .exc_en_o(exc),
    .mod_on_pulse_o(pon), .mod_off_pulse_o(poff), .fault_lock_o(lock)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int outs();
    return {26'd0, hv, trig, exc, pon, poff, lock};
  endfunction

  task automatic clear_in();
    hv_on = 0; hv_off = 0; mod_on = 0; mod_off = 0; fault = 0;
  endtask

  task automatic power_to_ready();
    clear_in();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    repeat (S + P + 1) step();
  endtask

  task automatic bring_to_run();
    power_to_ready();
    hv_on = 1; mod_on = 1;
    for (int i = 0; i < 50; i++) begin
      step();
      if (exc) break;
    end
  endtask

  task automatic t_reset_and_preheat();
    int first, quiet_bad;
    bring_to_run();
    rst_n = 0;
    #1;
    chk(outs() == 0, "R1", "outputs on reset while running", outs(), 0);
    repeat (3) step();
    chk(outs() == 0, "R1", "outputs held in reset", outs(), 0);
    first = 0; quiet_bad = 0;
    rst_n = 1;
    for (int n = 1; n <= S + P + 6; n++) begin
      step();
      if (hv && first == 0) first = n;
      if (n < S + P + 2 && outs() != 0) quiet_bad++;
    end
    chk(quiet_bad == 0, "R1", "outputs during settle/preheat", quiet_bad, 0);
    chk(first == S + P + 2, "R2", "hv rise edge", first, S + P + 2);
  endtask

  task automatic t_mod_ignored();
    power_to_ready();
    mod_on = 1;
    repeat (5) step();
    chk(outs() == 0, "R6", "mod on without hv", outs(), 0);
    mod_on = 0; hv_on = 1;
    step();
    chk(hv == 1, "R6", "hv up for ramp test", hv, 1);
    mod_on = 1;
    step();
    mod_on = 0;
    repeat (G + 3) step();
    chk(trig == 0 && hv == 1, "R6", "mod on during hv ramp", trig, 0);
  endtask

  task automatic t_bringup();
    int th, tt, te, ton, on_cnt, both;
    power_to_ready();
    hv_on = 1; mod_on = 1;
    th = 0; tt = 0; te = 0; ton = 0; on_cnt = 0; both = 0;
    for (int n = 1; n <= 40; n++) begin
      step();
      if (hv && th == 0) th = n;
      if (trig && tt == 0) tt = n;
      if (exc && te == 0) te = n;
      if (pon && ton == 0) ton = n;
      if (pon) on_cnt++;
      if (pon && poff) both++;
    end
    chk(tt - th == G + 1, "R3", "trig after hv", tt - th, G + 1);
    chk(te - tt == G, "R3", "exc after trig", te - tt, G);
    chk(ton == te, "R4", "on pulse start", ton, te);
    chk(on_cnt == W, "R4", "on pulse width", on_cnt, W);
    chk(both == 0, "R5", "pulses overlap", both, 0);
  endtask

  task automatic t_mod_off();
    int off_cnt;
    bring_to_run();
    repeat (4) step();
    mod_on = 0; mod_off = 1;
    step();
    mod_off = 0;
    off_cnt = poff;
    chk({hv, trig, exc} == 3'b110, "R7", "exc drops first", {hv, trig, exc}, 3'b110);
    step();
    off_cnt += poff;
    chk({hv, trig, exc} == 3'b100, "R7", "trig drops next", {hv, trig, exc}, 3'b100);
    step();
    off_cnt += poff;
    chk({hv, trig, exc} == 3'b100, "R7", "hv kept", {hv, trig, exc}, 3'b100);
    chk(off_cnt == W, "R4", "off pulse width", off_cnt, W);
    mod_on = 1;
    step();
    chk(trig == 1, "R7", "trig back on re-request", trig, 1);
  endtask

  task automatic t_hv_off();
    bring_to_run();
    repeat (3) step();
    hv_on = 0; mod_on = 0; hv_off = 1;
    step();
    chk({hv, trig, exc} == 3'b110, "R8", "exc off", {hv, trig, exc}, 3'b110);
    step();
    chk({hv, trig, exc} == 3'b100, "R8", "trig off", {hv, trig, exc}, 3'b100);
    step();
    chk({hv, trig, exc, lock} == 4'b0000, "R8", "hv off no lock",
        {hv, trig, exc, lock}, 0);
    hv_off = 0;
    repeat (4) step();
    hv_on = 1;
    step();
    chk(hv == 1, "R8", "hv back without preheat", hv, 1);
  endtask

  task automatic t_fault();
    bring_to_run();
    chk(pon == 1, "R4", "on pulse at exc rise", pon, 1);
    fault = 1;
    step();
    chk(exc == 0, "R9", "exc cut by fault", exc, 0);
    chk({pon, poff} == 2'b01, "R5", "on pulse truncated", {pon, poff}, 2'b01);
    chk({hv, trig} == 2'b11, "R9", "hv/trig held one edge", {hv, trig}, 2'b11);
    step();
    chk({hv, trig} == 2'b10, "R9", "trig off", {hv, trig}, 2'b10);
    step();
    chk({hv, lock} == 2'b01, "R9", "hv off and lock", {hv, lock}, 2'b01);
  endtask

  task automatic t_fault_recover();
    repeat (4) step();
    chk({hv, lock} == 2'b01, "R10", "lock with fault and on held", {hv, lock}, 2'b01);
    fault = 0;
    repeat (4) step();
    chk({hv, lock} == 2'b01, "R10", "lock without fresh on", {hv, lock}, 2'b01);
    hv_on = 0;
    step();
    chk(lock == 1, "R10", "lock while on low", lock, 1);
    hv_on = 1;
    step();
    chk({hv, lock} == 2'b10, "R10", "fresh on clears lock", {hv, lock}, 2'b10);
  endtask

  task automatic t_priority();
    power_to_ready();
    hv_on = 1; hv_off = 1;
    repeat (4) step();
    chk(hv == 0, "R11", "hv off beats on", hv, 0);
    hv_off = 0;
    step();
    chk(hv == 1, "R11", "hv on alone", hv, 1);
    repeat (G + 1) step();
    mod_on = 1; mod_off = 1;
    repeat (4) step();
    chk({hv, trig} == 2'b10, "R11", "mod off beats on", {hv, trig}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 0;
    #1;
    chk(outs() == 0, "R1", "outputs at reset", outs(), 0);
    t_reset_and_preheat();
    t_mod_ignored();
    t_bringup();
    t_mod_off();
    t_hv_off();
    t_fault();
    t_fault_recover();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule